// File: doc/BRIEF.md
# Paced Transfer Phase-Signal Detector

This block sits on the receive side of a double-edge paced link. Every transition of the link strobe, rising or falling, is one transfer. At each transfer the block samples the phase line. In steady state that line changes level on every second transfer. The block predicts the next phase level from the last two samples. A sample that disagrees with the prediction is a phase reversal, and each accepted reversal switches the decoded data state between invalid and valid.

After reset the decoded state is invalid and the detector is unlocked. It locks once it has counted a start-up preamble of phase transitions. Only after that does a reversal move the decoded state. While locked, the block emits a one-cycle valid pulse for each transfer decoded as valid.

It also polices the link. An invalid window that is too short, has odd length or contains no phase transition is flagged. So is a phase level held for too many transfers. The error flag is sticky until it is cleared, and it masks both the lock flag and the valid pulses.

Top module: `paced_p1_detector`

## Requirements
- R1: A transfer is sampled only in a clock cycle where `strb` differs from its value in the previous cycle. Rising and falling strobe edges count alike, and cycles without a strobe change leave all tracking state untouched.
- R2: With the two previous samples a and b (b the most recent), the predicted phase is NOT b when a equals b, and b otherwise. A sample that differs from the prediction is a reversal. While locked, each reversal toggles the decoded state, which starts out as invalid.
- R3: `locked` rises once PRE_TOGGLES phase transitions (sample differing from the previous sample) have been counted since reset. Reversals seen before then do not change the decoded state.
- R4: A decoded invalid window is the run of transfers from the reversal that enters invalid up to, but not including, the reversal that leaves it. If such a window is shorter than WIN_MIN transfers or has an odd length, `proto_err` is set at its exit. The invalid state that follows reset is exempt.
- R5: `data_vld` pulses high in the cycle after a sampled transfer whose decoded state is valid, and is low in every other cycle.
- R6: A sample that extends a run of equal phase levels beyond RUN_MAX consecutive transfers sets `proto_err`.
- R7: An invalid window with no phase transition after its entry transfer sets `proto_err` at its exit.
- R8: `proto_err` is sticky until `err_clr` is high. A new error in the same cycle as `err_clr` wins. While `proto_err` is high, `locked` and `data_vld` are low.
- R9: A synchronous `rst` clears the lock, the phase history, the run and transition counters, the decoded state and the error flag, so all outputs read 0 the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, fast enough to see every strobe transition |
| rst | input | 1 | Synchronous reset, active high |
| strb | input | 1 | Link strobe; each change is one transfer |
| p1 | input | 1 | Phase line, aligned with the data bits |
| err_clr | input | 1 | Clears the sticky error flag |
| data_vld | output | 1 | One-cycle pulse per transfer decoded as valid |
| locked | output | 1 | Preamble seen and no error pending |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
Clearing the error and detecting a new error can happen in the same cycle. The bench raises `err_clr` on the very transfer that completes an over-long phase run, and expects `proto_err` to stay high with no valid pulse. Window-length and run-length errors can also fall on one transfer, because a window with no transition is also an over-long run. The bench checks that this double cause yields one flagged error that a single clear removes. A behavioural reference model with a sample queue tracks every cycle, and all three outputs are compared on each clock.

// File: rtl/paced_p1_detector.sv
module paced_p1_detector #(
  parameter int PRE_TOGGLES = 16,
  parameter int RUN_MAX     = 3,
  parameter int WIN_MIN     = 4,
  parameter int WIN_W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strb,
  input  logic p1,
  input  logic err_clr,
  output logic data_vld,
  output logic locked,
  output logic proto_err
);
  localparam int TW = $clog2(PRE_TOGGLES + 1);
  localparam int RW = $clog2(RUN_MAX + 2);
  localparam logic [WIN_W-1:0] WMAX = '1;

  logic             strb_q, h1, h2, st, wchk, wtog, err, vld;
  logic [1:0]       hist;
  logic [TW-1:0]    tcnt;
  logic [RW-1:0]    run;
  logic [WIN_W-1:0] wlen;

  wire smp     = strb ^ strb_q;
  wire pred    = (h1 == h2) ? ~h1 : h1;
  wire tog     = (hist != 2'd0) && (p1 != h1);
  wire rev     = (hist == 2'd2) && (p1 != pred);
  wire lk      = (tcnt == TW'(PRE_TOGGLES));
  wire flip    = rev & lk;
  wire nst     = st ^ flip;
  wire run_err = (hist != 2'd0) && !tog && (run >= RW'(RUN_MAX));
  wire win_err = !st && flip && wchk &&
                 ((wlen < WIN_W'(WIN_MIN)) || wlen[0] || !wtog);
  wire err_n   = (smp && (run_err || win_err)) || (err && !err_clr);

  assign data_vld  = vld;
  assign proto_err = err;
  assign locked    = lk & ~err;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= strb;
      hist   <= '0;
      h1     <= 1'b0;
      h2     <= 1'b0;
      tcnt   <= '0;
      run    <= '0;
      st     <= 1'b0;
      wchk   <= 1'b0;
      wtog   <= 1'b0;
      wlen   <= '0;
      err    <= 1'b0;
      vld    <= 1'b0;
    end else begin
      strb_q <= strb;
      err    <= err_n;
      vld    <= smp & nst & ~err_n;
      if (smp) begin
        h1 <= p1;
        h2 <= h1;
        if (hist != 2'd2) hist <= hist + 2'd1;
        if (tog || hist == 2'd0) run <= RW'(1);
        else if (run <= RW'(RUN_MAX)) run <= run + RW'(1);
        if (tog && !lk) tcnt <= tcnt + TW'(1);
        st <= nst;
        if (st && flip) begin
          wchk <= 1'b1;
          wlen <= WIN_W'(1);
          wtog <= 1'b0;
        end else if (!st && flip) begin
          wchk <= 1'b0;
        end else if (!st) begin
          wlen <= (wlen == WMAX) ? wlen - WIN_W'(1) : wlen + WIN_W'(1);
          wtog <= wtog | tog;
        end
      end
    end
  end

  AST_VLD_ONLY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    data_vld |-> $past(strb) != $past(strb_q)); // R5

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !smp |=> $stable(st) && $stable(h1) && $stable(run)); // R1

  AST_NO_FLIP_BEFORE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (smp && !lk) |=> $stable(st)); // R3

  AST_SHORT_WINDOW_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (smp && flip && !st && wchk && wlen < WIN_W'(WIN_MIN)) |=> proto_err); // R4

  AST_LONG_RUN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (smp && hist != 2'd0 && p1 == h1 && run >= RW'(RUN_MAX)) |=> proto_err); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (proto_err && !err_clr) |=> proto_err); // R8

  AST_ERR_MASKS_VALID: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> !data_vld); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !locked && !data_vld && !proto_err); // R9
endmodule

// File: tb/test_paced_p1_detector.sv
module test_paced_p1_detector;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 16;

  logic clk = 1'b0, rst = 1'b1, strb = 1'b0, p1 = 1'b0, err_clr = 1'b0;
  logic data_vld, locked, proto_err;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paced_p1_detector #(.PRE_TOGGLES(PRE)) i_paced_p1_detector (
    .clk(clk), .rst(rst), .strb(strb), .p1(p1), .err_clr(err_clr),
    .data_vld(data_vld), .locked(locked), .proto_err(proto_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  bit mq[$];
  int mt = 0, mrun = 0, mwlen = 0;
  bit mst = 0, mwchk = 0, mwtog = 0, merr = 0, mvld = 0, mstrb = 0;
  bit m_smp, m_e, m_lkd, m_tg, m_rv, m_pd, m_flip, m_werr, m_rerr;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); mt = 0; mrun = 0; mwlen = 0;
      mst = 0; mwchk = 0; mwtog = 0; merr = 0; mvld = 0;
    end else begin
      m_smp = (strb != mstrb);
      m_e = merr && !err_clr;
      mvld = 0;
      if (m_smp) begin
        m_lkd = (mt >= PRE);
        m_tg = (mq.size() > 0) && (p1 != mq[$]);
        m_rv = 0;
        if (mq.size() >= 2) begin
          m_pd = (mq[$] == mq[$-1]) ? !mq[$] : mq[$];
          m_rv = (p1 != m_pd);
        end
        m_flip = m_rv && m_lkd;
        m_rerr = (mq.size() > 0) && !m_tg && (mrun >= 3);
        m_werr = !mst && m_flip && mwchk && (mwlen < 4 || (mwlen % 2) == 1 || !mwtog);
        mrun = (m_tg || mq.size() == 0) ? 1 : mrun + 1;
        if (m_tg && !m_lkd) mt++;
        if (mst && m_flip) begin mwchk = 1; mwlen = 1; mwtog = 0; end
        else if (!mst && m_flip) mwchk = 0;
        else if (!mst) begin mwlen++; mwtog = mwtog | m_tg; end
        mst = mst ^ m_flip;
        mq.push_back(p1);
        if (mq.size() > 2) void'(mq.pop_front());
        if (m_rerr || m_werr) m_e = 1;
        mvld = mst && !m_e;
      end
      merr = m_e;
    end
    mstrb = strb;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(data_vld == mvld, "R5 data_vld vs model", data_vld, mvld);
      chk(locked == ((mt >= PRE) && !merr), "R3 locked vs model", locked, (mt >= PRE) && !merr);
      chk(proto_err == merr, "R8 proto_err vs model", proto_err, merr);
    end
  end

  // driver: keeps its own phase history
  bit d1 = 0, d2 = 0;
  int dn = 0;

  task automatic put(input bit v);
    strb = ~strb; p1 = v;
    d2 = d1; d1 = v; dn++;
    @(negedge clk);
  endtask
  function automatic bit dpred();
    if (dn < 2) return 1'b0;
    return (d1 == d2) ? !d1 : d1;
  endfunction
  task automatic nrm(input int n);
    for (int i = 0; i < n; i++) put(dpred());
  endtask
  task automatic rev();
    put(!dpred());
  endtask
  task automatic idle();
    @(negedge clk);
  endtask
  task automatic clear();
    err_clr = 1; @(negedge clk); err_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0; @(negedge clk);
    chk(!locked && !data_vld && !proto_err, "R9 outputs after reset", {locked, data_vld, proto_err}, 0);
    nrm(8);
    rev();
    chk(data_vld == 0, "R3 reversal before lock ignored", data_vld, 0);
    nrm(40);
    chk(locked == 1, "R3 locked after preamble", locked, 1);
    chk(data_vld == 0, "R2 still invalid before first reversal", data_vld, 0);
    rev();
    chk(data_vld == 1, "R2 reversal enters valid", data_vld, 1);
    idle();
    chk(data_vld == 0, "R1 no pulse without strobe change", data_vld, 0);
    nrm(5);
    chk(data_vld == 1, "R5 valid pulse on valid transfer", data_vld, 1);
    rev();
    chk(data_vld == 0, "R2 reversal enters invalid", data_vld, 0);
    nrm(3); rev();
    chk(data_vld == 1 && proto_err == 0, "R4 window of four accepted", proto_err, 0);
    nrm(4); rev(); nrm(5); rev();
    chk(proto_err == 0, "R4 window of six accepted", proto_err, 0);
    nrm(3); rev(); nrm(1); rev();
    chk(proto_err == 1, "R4 window of two flagged", proto_err, 1);
    chk(locked == 0, "R8 lock masked by error", locked, 0);
    nrm(3);
    chk(data_vld == 0 && proto_err == 1, "R8 error sticky, valid suppressed", data_vld, 0);
    clear();
    chk(proto_err == 0 && locked == 1, "R8 clear restores lock", proto_err, 0);
    nrm(2); rev(); nrm(4); rev();
    chk(proto_err == 1, "R4 odd window of five flagged", proto_err, 1);
    clear();
    nrm(4);
    put(d1); put(d1);
    chk(proto_err == 1, "R6 run beyond limit flagged", proto_err, 1);
    clear();
    chk(proto_err == 0, "R6 cleared", proto_err, 0);
    nrm(6);
    err_clr = 1; put(d1); put(d1); err_clr = 0;
    chk(proto_err == 1, "R8 new error beats clear", proto_err, 1);
    clear();
    nrm(6);
    if (data_vld == 0) rev();
    nrm(2); rev();
    put(d1); put(d1); put(d1);
    chk(proto_err == 1, "R7 window without transition flagged", proto_err, 1);
    clear();
    chk(proto_err == 0, "R7 single clear removes error", proto_err, 0);
    nrm(4);
    rst = 1; @(negedge clk); rst = 0;
    chk(!locked && !data_vld && !proto_err, "R9 reset mid-stream", locked, 0);
    dn = 0; nrm(10);
    chk(locked == 0, "R9 lock needs new preamble", locked, 0);
    nrm(30);
    chk(locked == 1, "R3 relock after reset", locked, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule